// File: doc/BRIEF.md
# Timer capture/compare PWM channel

One channel of a 16-bit free-running timer. The shared counter value and a one-cycle overflow pulse come in from outside, and software reaches the channel over an 8-bit register bus. In capture mode the channel watches an input pin, passes it through a two-stage synchronizer, and on a selected edge copies the counter value into its 16-bit channel register. In compare mode it drives an output pin that changes on a counter match and can also toggle on each counter overflow. Together these form a simple edge-aligned PWM.

A max-duty control holds the PWM output high for whole periods. It is sampled only at overflow, so a change always takes effect at the next period boundary. The 16-bit channel register is reached as two bytes. Reading the high byte in capture mode freezes the register until the low byte has been read. Writing the high byte in compare mode stops matches until the low byte has also been written.

Register map (address on `bus_addr_i`):
- 0: control.
  - bit0 max-duty
  - bit1 toggle-on-overflow
  - bits3:2 edge/action select
  - bits5:4 mode select
  - bit6 reads 0
  - bit7 event flag
- 1: channel register, high byte.
- 2: channel register, low byte.
- 3: reads 0.

Top module: `tim_chan`

## Requirements
- R1: After reset, the control register reads 0x00, `pin_o` is 0 and `flag_o` is 0. The channel register value after reset is undefined.
- R2: In capture mode (mode bits 5:4 = 00), an edge on `pin_i` copies `cnt_i` into the channel register and sets the flag. The edge is judged after two synchronizer stages. Edge select bits 3:2 choose the edge: 01 rising only, 10 falling only, 11 either edge, 00 no capture. An edge that is not selected leaves the register unchanged.
- R3: In capture mode, a read of address 1 blocks all captures until address 2 is read.
- R4: In compare mode (mode bits 5:4 not 00), a cycle with `cnt_i` equal to the channel register is a match, and a match sets the flag. With select 01 a match toggles `pin_o`, and `pin_o` shows the change while the counter holds the next value.
- R5: In compare mode, select 11 sets the pin on a match, select 10 clears it, and select 00 leaves it unchanged.
- R6: In compare mode with bit1 set, every `ovf_i` pulse toggles `pin_o`. With bit1 clear, overflow does not change the pin.
- R7: When an overflow and a match fall in the same cycle with bit1 set, the overflow toggle is applied and the match action is discarded.
- R8: In capture mode, bit1 has no effect: `pin_o` stays unchanged across overflows.
- R9: With bit1 set, max-duty (bit0) is sampled at each overflow. In the periods after an overflow that saw bit0 = 1, `pin_o` is held at 1. Setting or clearing bit0 mid-period therefore changes nothing until the next overflow.
- R10: In compare mode, a write to address 1 suppresses all matches until address 2 is written. The full 16-bit value is then compared.
- R11: The flag (bit7 of address 0) is cleared by reading address 0 while the flag is set, then writing address 0 with bit7 = 0. A control write that is not preceded by such a read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared timer counter value |
| ovf_i | input | 1 | One-cycle pulse in the cycle the counter wraps |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| pin_i | input | 1 | Capture input pin (asynchronous) |
| pin_o | output | 1 | Compare / PWM output pin |
| flag_o | output | 1 | Capture/compare event flag |

## Verification
A counter overflow and a compare match can land in the same cycle. The bench provokes this by programming the compare value equal to the counter's wrap value, with toggle-on-overflow enabled and a clear or set action selected. The outcome is judged by the pin level while the counter holds 0: only a toggle explains the observed level in both cases. The max-duty latch also meets the overflow edge: the bit is set and cleared mid-period, and the pin is checked both in the rest of that period and in the following period.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_VHI  = 2'd1;
  localparam logic [1:0] A_VLO  = 2'd2;

  localparam int unsigned CB_MAXD = 0;
  localparam int unsigned CB_TOV  = 1;
  localparam int unsigned CB_SEL  = 2;
  localparam int unsigned CB_MODE = 4;
  localparam int unsigned CB_FLAG = 7;

  // compare actions in output mode
  localparam logic [1:0] ACT_TGL = 2'b01;
  localparam logic [1:0] ACT_CLR = 2'b10;
  localparam logic [1:0] ACT_SET = 2'b11;
endpackage

// File: rtl/tim_chan_edge.sv
module tim_chan_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tim_chan_val.sv
module tim_chan_val #(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt_i,
  input  logic          cap_mode_i,
  input  logic          cap_ev_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic          rd_hi_i,
  input  logic          rd_lo_i,
  input  logic [BW-1:0] wdata_i,
  output logic [W-1:0]  val_o,
  output logic          cap_o,
  output logic          match_o
);
  localparam int unsigned HB = W - BW;

  logic [W-1:0] val_q, val_d;
  logic lock_q, lock_d, inh_q, inh_d;

  assign cap_o = cap_mode_i & cap_ev_i & ~lock_q;

  always_comb begin
    lock_d = lock_q;
    if (rd_lo_i)                    lock_d = 1'b0;
    else if (rd_hi_i && cap_mode_i) lock_d = 1'b1;
    inh_d = inh_q;
    if (wr_lo_i)      inh_d = 1'b0;
    else if (wr_hi_i) inh_d = 1'b1;
    val_d = val_q;
    if (cap_o)   val_d = cnt_i;
    if (wr_hi_i) val_d[W-1:BW] = wdata_i[HB-1:0];
    if (wr_lo_i) val_d[BW-1:0] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      inh_q  <= inh_d;
    end
  end

  // value register is deliberately left without reset
  always_ff @(posedge clk) val_q <= val_d;

  assign val_o   = val_q;
  assign match_o = ~cap_mode_i & ~inh_q & (cnt_i == val_q);

  // R3
  cap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !wr_hi_i && !wr_lo_i) |=> $stable(val_q));
endmodule

// File: rtl/tim_chan_pin.sv
module tim_chan_pin
  import tim_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_mode_i,
  input  logic       tov_i,
  input  logic       maxd_i,
  input  logic [1:0] act_i,
  input  logic       match_i,
  input  logic       ovf_i,
  output logic       pin_o
);
  logic pin_q, pin_d, maxd_q, maxd_d, forced;

  assign forced = oc_mode_i & tov_i & maxd_q;

  always_comb begin
    maxd_d = maxd_q;
    if (ovf_i) maxd_d = maxd_i;
    pin_d = pin_q;
    if (oc_mode_i) begin
      if (tov_i && ovf_i)  pin_d = (maxd_q | maxd_i) ? 1'b1 : ~pin_q;
      else if (forced)     pin_d = 1'b1;
      else if (match_i) begin
        case (act_i)
          ACT_TGL: pin_d = ~pin_q;
          ACT_CLR: pin_d = 1'b0;
          ACT_SET: pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      maxd_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      maxd_q <= maxd_d;
    end
  end

  assign pin_o = pin_q;

  // R4
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_mode_i || (!match_i && !ovf_i && !forced)) |=> $stable(pin_q));
  // R7
  ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode_i && tov_i && ovf_i && match_i && !maxd_q && !maxd_i)
      |=> (pin_q != $past(pin_q)));
  // R9
  maxd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> pin_q);
  // R9
  maxd_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_mode_i && tov_i && !maxd_q && !ovf_i && match_i && act_i == ACT_CLR)
      |=> !pin_q);
endmodule

// File: rtl/tim_chan.sv
module tim_chan
  import tim_chan_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             flag_o
);
  localparam int unsigned CTL_W = CB_MODE + 2;

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic flag_q, flag_d, armed_q, armed_d;
  logic wr_ctl, rd_ctl, wr_hi, wr_lo, rd_hi, rd_lo;
  logic cap_mode, rise, fall, cap_ev, cap, match;
  logic [CNT_W-1:0] val;
  logic unused_wbits;

  assign wr_ctl = bus_wr_i & (bus_addr_i == A_CTRL);
  assign rd_ctl = bus_rd_i & (bus_addr_i == A_CTRL);
  assign wr_hi  = bus_wr_i & (bus_addr_i == A_VHI);
  assign wr_lo  = bus_wr_i & (bus_addr_i == A_VLO);
  assign rd_hi  = bus_rd_i & (bus_addr_i == A_VHI);
  assign rd_lo  = bus_rd_i & (bus_addr_i == A_VLO);
  assign unused_wbits = ^bus_wdata_i[BUS_W-1:CTL_W];

  assign cap_mode = (ctrl_q[CB_MODE +: 2] == 2'b00);
  assign cap_ev   = (ctrl_q[CB_SEL] & rise) | (ctrl_q[CB_SEL+1] & fall);

  tim_chan_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  tim_chan_val #(.W(CNT_W), .BW(BUS_W)) u_val (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cap_mode_i(cap_mode),
    .cap_ev_i(cap_ev), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .rd_hi_i(rd_hi),
    .rd_lo_i(rd_lo), .wdata_i(bus_wdata_i), .val_o(val), .cap_o(cap),
    .match_o(match)
  );

  tim_chan_pin u_pin (
    .clk(clk), .rst_n(rst_n), .oc_mode_i(~cap_mode), .tov_i(ctrl_q[CB_TOV]),
    .maxd_i(ctrl_q[CB_MAXD]), .act_i(ctrl_q[CB_SEL +: 2]), .match_i(match),
    .ovf_i(ovf_i), .pin_o(pin_o)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctl) ctrl_d = bus_wdata_i[CTL_W-1:0];
    armed_d = armed_q;
    if (wr_ctl)               armed_d = 1'b0;
    else if (rd_ctl && flag_q) armed_d = 1'b1;
    flag_d = flag_q;
    if (cap || match)                                flag_d = 1'b1;
    else if (wr_ctl && !bus_wdata_i[CB_FLAG] && armed_q) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[CTL_W-1:0] = ctrl_q;
        bus_rdata_o[CB_FLAG]   = flag_q;
      end
      A_VHI:   bus_rdata_o = val[CNT_W-1:BUS_W];
      A_VLO:   bus_rdata_o = val[BUS_W-1:0];
      default: bus_rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;

  // R2
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> flag_q);
  // R11
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !match) |=> !$rose(flag_q));
  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctl && !bus_wdata_i[CB_FLAG] && armed_q)) |=> flag_q);
endmodule

// File: tb/tim_chan_tb.sv
`timescale 1ns/1ps
module tim_chan_tb;
  localparam logic [15:0] MOD = 16'd19;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] cnt, ld_val;
  logic ld, run, ovf;
  logic [1:0] addr;
  logic wr, rd, pin_in;
  logic [7:0] wdata, rdata;
  logic pin_out, flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ld)       cnt <= ld_val;
    else if (run) cnt <= (cnt == MOD) ? 16'd0 : cnt + 16'd1;
  end
  assign ovf = run && !ld && (cnt == MOD);

  tim_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .ovf_i(ovf), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .flag_o(flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; ld = 1'b0; ld_val = '0;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; pin_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #0.5 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); ld = 1'b1; ld_val = v;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] c);
    do @(negedge clk); while (cnt != c);
  endtask

  task automatic oc_setup(input logic [15:0] v, input logic [7:0] c);
    do_reset();
    load(16'd0);
    wr_reg(2'd1, v[15:8]);
    wr_reg(2'd2, v[7:0]);
    wr_reg(2'd0, c);
    @(negedge clk); run = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd_reg(2'd0, d);
    chk("R1 ctrl", {8'h0, d}, 16'h0000);
    chk("R1 pin", {15'd0, pin_out}, 16'd0);
    chk("R1 flag", {15'd0, flag}, 16'd0);
  endtask

  task automatic t_capture();
    logic [7:0] h, l;
    do_reset();
    wr_reg(2'd0, 8'h04);
    load(16'h1234); drive_pin(1'b1);
    chk("R2 flag", {15'd0, flag}, 16'd1);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 rising", {h, l}, 16'h1234);
    load(16'h4321); drive_pin(1'b0);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 falling ignored", {h, l}, 16'h1234);
    wr_reg(2'd0, 8'h08);
    load(16'h5555); drive_pin(1'b1);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 rising ignored", {h, l}, 16'h1234);
    load(16'h4321); drive_pin(1'b0);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 falling", {h, l}, 16'h4321);
    wr_reg(2'd0, 8'h0C);
    load(16'h0A0B); drive_pin(1'b1);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 both rise", {h, l}, 16'h0A0B);
    load(16'h0C0D); drive_pin(1'b0);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R2 both fall", {h, l}, 16'h0C0D);
  endtask

  task automatic t_lock();
    logic [7:0] h, l;
    do_reset();
    wr_reg(2'd0, 8'h04);
    load(16'h1234); drive_pin(1'b1);
    rd_reg(2'd1, h);
    load(16'h5678); drive_pin(1'b0); drive_pin(1'b1);
    rd_reg(2'd2, l);
    chk("R3 locked", {h, l}, 16'h1234);
    drive_pin(1'b0); drive_pin(1'b1);
    rd_reg(2'd1, h); rd_reg(2'd2, l);
    chk("R3 unlocked", {h, l}, 16'h5678);
  endtask

  task automatic t_toggle();
    logic [7:0] d;
    oc_setup(16'd7, 8'h14);
    wait_cnt(16'd7); chk("R4 before match", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd8); chk("R4 after match", {15'd0, pin_out}, 16'd1);
    rd_reg(2'd0, d); chk("R4 flag", {8'h0, d}, 16'h0094);
    wait_cnt(16'd8); chk("R4 second toggle", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_actions();
    oc_setup(16'd7, 8'h1C);
    wait_cnt(16'd8); chk("R5 set", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd12); wr_reg(2'd0, 8'h10);
    wait_cnt(16'd8); chk("R5 none", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd12); wr_reg(2'd0, 8'h18);
    wait_cnt(16'd8); chk("R5 clear", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_tov();
    oc_setup(16'd7, 8'h12);
    wait_cnt(MOD);   chk("R6 pre ovf", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd0); chk("R6 ovf1", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd0); chk("R6 ovf2", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd0);
    wr_reg(2'd0, 8'h10);
    wait_cnt(16'd1); wait_cnt(16'd1);
    chk("R6 tov off", {15'd0, pin_out}, 16'd1);
  endtask

  task automatic t_collide();
    oc_setup(MOD, 8'h1A);
    wait_cnt(MOD);   chk("R7 pre", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd0); chk("R7 clear loses", {15'd0, pin_out}, 16'd1);
    oc_setup(MOD, 8'h1E);
    wait_cnt(16'd0); chk("R7 set 1", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd0); chk("R7 set loses", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_cap_tov();
    oc_setup(16'd7, 8'h02);
    wait_cnt(16'd1); wait_cnt(16'd1);
    chk("R8 no toggle", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_maxd();
    oc_setup(16'd5, 8'h1A);
    wait_cnt(16'd3); chk("R9 first period", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd3); chk("R9 pwm high", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd8); chk("R9 pwm low", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd10); wr_reg(2'd0, 8'h1B);
    wait_cnt(16'd15); chk("R9 set late", {15'd0, pin_out}, 16'd0);
    wait_cnt(16'd3);  chk("R9 forced a", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd8);  chk("R9 forced b", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd10); wr_reg(2'd0, 8'h1A);
    wait_cnt(16'd15); chk("R9 clear late", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd3);  chk("R9 normal high", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd8);  chk("R9 normal low", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_inhibit();
    oc_setup(16'd7, 8'h14);
    wait_cnt(16'd8); chk("R10 base", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd12); wr_reg(2'd1, 8'h00);
    wait_cnt(16'd8); chk("R10 suppressed", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd12); wr_reg(2'd2, 8'h09);
    wait_cnt(16'd8);  chk("R10 old value dead", {15'd0, pin_out}, 16'd1);
    wait_cnt(16'd10); chk("R10 new value", {15'd0, pin_out}, 16'd0);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    do_reset();
    wr_reg(2'd0, 8'h04);
    load(16'h0055); drive_pin(1'b1);
    wr_reg(2'd0, 8'h04);
    chk("R11 unarmed write", {15'd0, flag}, 16'd1);
    rd_reg(2'd0, d);
    chk("R11 read", {8'h0, d}, 16'h0084);
    wr_reg(2'd0, 8'h04);
    chk("R11 cleared", {15'd0, flag}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_lock();
    t_toggle();
    t_actions();
    t_tov();
    t_collide();
    t_cap_tov();
    t_maxd();
    t_inhibit();
    t_flag();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule